// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software by counting slow ticks. A 1 kHz tick arrives as a single-cycle strobe in the system clock domain. Software must pulse the restart input often enough, or the block raises a one-cycle reset request for the system reset generator. In normal mode the only rule is a deadline: the counter must be restarted before the selected timeout length in ticks has passed.

In window mode each period has two phases. A closed phase, whose length is the window setting, comes first. An open phase, whose length is the timeout setting, follows it. A restart in the open phase is accepted and starts a new closed phase. A restart in the closed phase is a fault. Reaching the end of the open phase with no restart is also a fault.

Settings are protected. A write counts only when it follows an unlock strobe within a short window of system clocks. A lock input freezes every setting until the next reset, so the watchdog cannot be switched off once it is locked.

Top module: `wwdt_top`

## Requirements
- R1: After reset the block is disabled and in normal mode, both period codes are 0, it is unlocked and `rst_req` is low. While disabled no number of ticks raises `rst_req`.
- R2: A period code c below NUM_CODES selects 2^(c+BASE_SHIFT) ticks. Any code from NUM_CODES up to 2^CODE_W-1 selects the longest period, 2^(NUM_CODES-1+BASE_SHIFT) ticks. With the defaults this gives 8 to 8192 ticks.
- R3: In normal mode `rst_req` is high in the cycle after the clock that samples the L-th tick since the last restart, where L is the timeout length. It stays low for the first L-1 ticks.
- R4: In normal mode a `kick` while enabled restarts the count from zero. If `kick` and `tick` are sampled on the same clock, the kick wins and that tick is not counted.
- R5: In window mode a `kick` during the closed phase raises `rst_req` in the next cycle. This includes a kick after W-1 of the W closed-phase ticks.
- R6: In window mode the W-th closed-phase tick opens the window. A `kick` during the open phase is accepted and starts a new closed phase. If the open phase receives its T-th tick with no kick, `rst_req` is raised. A kick after T-1 open-phase ticks is still accepted.
- R7: `rst_req` lasts exactly one cycle per timeout. After it the count restarts from zero, in the closed phase, with the settings unchanged.
- R8: While disabled, `kick` and `tick` have no effect and `rst_req` stays low. This holds in both modes.
- R9: A `cfg_we` is accepted only if it is sampled on one of the UNLOCK_WIN clocks that follow the clock sampling `unlock` (4 by default). A write on the same clock as `unlock`, a later write, or a write with no unlock is ignored. An accepted write loads all four fields, closes the unlock window and restarts the count from zero in the closed phase.
- R10: Once `lock_req` has been sampled high, every write is ignored until `rst_n` is asserted. A locked, enabled watchdog therefore cannot be disabled.
- R11: Clocks without `tick` do not advance the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Single-cycle 1 kHz tick strobe |
| kick | input | 1 | Restart strobe from software |
| unlock | input | 1 | Opens the short write-acceptance window |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | Write data: 1 enables the watchdog |
| cfg_window | input | 1 | Write data: 1 selects window mode, 0 normal mode |
| cfg_tmo_code | input | CODE_W | Write data: timeout (open-phase) period code |
| cfg_win_code | input | CODE_W | Write data: closed-phase period code |
| lock_req | input | 1 | Sticky lock request, held until reset |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with BASE_SHIFT=1, keeping CODE_W=4, NUM_CODES=11 and UNLOCK_WIN=4. This shrinks the periods to 2 through 2048 ticks. It becomes cheap to sweep all sixteen timeout codes, including the five reserved ones, in normal mode, and each is checked at its exact firing tick. The shorter periods also allow window-mode sweeps across several pairs of timeout and window codes. These sweeps cover early kicks at the last closed tick, accepted kicks at the last open tick, and late faults. The unlock window is probed at its edges: the same clock as the unlock, the fourth clock after it and the fifth.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;

   typedef enum logic {
      PH_CLOSED = 1'b0,
      PH_OPEN   = 1'b1
   } wwdt_phase_e;

   // shift amount selected by a period code; reserved codes clamp to the longest
   function automatic int unsigned wwdt_shift(input int unsigned code,
                                              input int unsigned num_codes,
                                              input int unsigned base_shift);
      int unsigned c;
      c = (code < num_codes) ? code : (num_codes - 1);
      return c + base_shift;
   endfunction

endpackage

// File: rtl/wwdt_period_dec.sv
module wwdt_period_dec #(
   parameter int unsigned CODE_W     = 4,
   parameter int unsigned NUM_CODES  = 11,
   parameter int unsigned BASE_SHIFT = 3,
   parameter int unsigned CNT_W      = NUM_CODES + BASE_SHIFT
) (
   input  logic [CODE_W-1:0] code_i,
   output logic [CNT_W-1:0]  len_o
);
   import wwdt_pkg::*;

   localparam int unsigned NCODE_ALL = 1 << CODE_W;

   logic [CNT_W-1:0] tbl [NCODE_ALL];

   for (genvar g = 0; g < NCODE_ALL; g++) begin : g_tbl
      localparam int unsigned SH = wwdt_shift(g, NUM_CODES, BASE_SHIFT);
      assign tbl[g] = CNT_W'(1) << SH;
   end

   always_comb begin
      len_o = tbl[code_i];
   end

   always_comb begin
      if (!$isunknown(code_i)) begin
         assert_len_pow2_R2: assert ($countones(len_o) == 1)
            else $error("period length is not a power of two");
      end
   end

endmodule

// File: rtl/wwdt_cfg_guard.sv
module wwdt_cfg_guard #(
   parameter int unsigned CODE_W     = 4,
   parameter int unsigned UNLOCK_WIN = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              unlock,
   input  logic              cfg_we,
   input  logic              cfg_en,
   input  logic              cfg_window,
   input  logic [CODE_W-1:0] cfg_tmo_code,
   input  logic [CODE_W-1:0] cfg_win_code,
   input  logic              lock_req,
   output logic              en_q,
   output logic              win_q,
   output logic [CODE_W-1:0] tmo_code_q,
   output logic [CODE_W-1:0] win_code_q,
   output logic              upd_q
);
   localparam int unsigned UW_W = $clog2(UNLOCK_WIN + 1);

   logic [UW_W-1:0] ucnt_q;
   logic            lock_q;
   logic            accept;

   assign accept = cfg_we && (ucnt_q != '0) && !lock_q && !lock_req;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ucnt_q     <= '0;
         lock_q     <= 1'b0;
         en_q       <= 1'b0;
         win_q      <= 1'b0;
         tmo_code_q <= '0;
         win_code_q <= '0;
         upd_q      <= 1'b0;
      end else begin
         lock_q <= lock_q | lock_req;
         upd_q  <= accept;
         if (unlock) begin
            ucnt_q <= UW_W'(UNLOCK_WIN);
         end else if (accept) begin
            ucnt_q <= '0;
         end else if (ucnt_q != '0) begin
            ucnt_q <= ucnt_q - UW_W'(1);
         end
         if (accept) begin
            en_q       <= cfg_en;
            win_q      <= cfg_window;
            tmo_code_q <= cfg_tmo_code;
            win_code_q <= cfg_win_code;
         end
      end
   end

   assert_lock_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> $stable({en_q, win_q, tmo_code_q, win_code_q}))
      else $error("settings changed while locked");

   assert_closed_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_we || ucnt_q == '0) |=> $stable({en_q, win_q, tmo_code_q, win_code_q}))
      else $error("settings changed outside the unlock window");

endmodule

// File: rtl/wwdt_core.sv
module wwdt_core #(
   parameter int unsigned CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             win,
   input  logic             restart,
   input  logic [CNT_W-1:0] tmo_len,
   input  logic [CNT_W-1:0] win_len,
   input  logic             tick,
   input  logic             kick,
   output logic             rst_req
);
   import wwdt_pkg::*;

   logic [CNT_W-1:0] cnt_q, cnt_n;
   wwdt_phase_e      ph_q, ph_n;
   logic             fault;
   logic             in_closed;

   assign in_closed = win && (ph_q == PH_CLOSED);

   always_comb begin
      cnt_n = cnt_q;
      ph_n  = ph_q;
      fault = 1'b0;
      if (!en || restart) begin
         cnt_n = '0;
         ph_n  = PH_CLOSED;
      end else if (kick) begin
         fault = in_closed;
         cnt_n = '0;
         ph_n  = PH_CLOSED;
      end else if (tick) begin
         if (in_closed) begin
            if (cnt_q == win_len - CNT_W'(1)) begin
               cnt_n = '0;
               ph_n  = PH_OPEN;
            end else begin
               cnt_n = cnt_q + CNT_W'(1);
            end
         end else if (cnt_q == tmo_len - CNT_W'(1)) begin
            fault = 1'b1;
            cnt_n = '0;
            ph_n  = PH_CLOSED;
         end else begin
            cnt_n = cnt_q + CNT_W'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         ph_q    <= PH_CLOSED;
         rst_req <= 1'b0;
      end else begin
         cnt_q   <= cnt_n;
         ph_q    <= ph_n;
         rst_req <= fault;
      end
   end

   assert_quiet_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !rst_req)
      else $error("reset request while disabled");

   assert_early_kick_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !restart && kick && win && ph_q == PH_CLOSED) |=> rst_req)
      else $error("early kick not reported");

   assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !restart) |-> (cnt_q < (in_closed ? win_len : tmo_len)))
      else $error("count beyond its phase length");

endmodule

// File: rtl/wwdt_top.sv
module wwdt_top #(
   parameter int unsigned CODE_W     = 4,
   parameter int unsigned NUM_CODES  = 11,
   parameter int unsigned BASE_SHIFT = 3,
   parameter int unsigned UNLOCK_WIN = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              kick,
   input  logic              unlock,
   input  logic              cfg_we,
   input  logic              cfg_en,
   input  logic              cfg_window,
   input  logic [CODE_W-1:0] cfg_tmo_code,
   input  logic [CODE_W-1:0] cfg_win_code,
   input  logic              lock_req,
   output logic              rst_req
);
   localparam int unsigned CNT_W = NUM_CODES + BASE_SHIFT;

   if (NUM_CODES < 1 || NUM_CODES > (1 << CODE_W)) begin : g_bad_codes
      $error("NUM_CODES must lie in 1 .. 2**CODE_W");
   end
   if (UNLOCK_WIN < 1) begin : g_bad_unlock
      $error("UNLOCK_WIN must be at least 1");
   end

   logic              en_q, win_q, upd_q;
   logic [CODE_W-1:0] tmo_code_q, win_code_q;
   logic [CNT_W-1:0]  tmo_len, win_len;

   wwdt_cfg_guard #(.CODE_W(CODE_W), .UNLOCK_WIN(UNLOCK_WIN)) u_cfg (
      .clk(clk), .rst_n(rst_n), .unlock(unlock), .cfg_we(cfg_we),
      .cfg_en(cfg_en), .cfg_window(cfg_window), .cfg_tmo_code(cfg_tmo_code),
      .cfg_win_code(cfg_win_code), .lock_req(lock_req), .en_q(en_q),
      .win_q(win_q), .tmo_code_q(tmo_code_q), .win_code_q(win_code_q),
      .upd_q(upd_q)
   );

   wwdt_period_dec #(.CODE_W(CODE_W), .NUM_CODES(NUM_CODES),
                     .BASE_SHIFT(BASE_SHIFT), .CNT_W(CNT_W)) u_tmo_dec (
      .code_i(tmo_code_q), .len_o(tmo_len)
   );

   wwdt_period_dec #(.CODE_W(CODE_W), .NUM_CODES(NUM_CODES),
                     .BASE_SHIFT(BASE_SHIFT), .CNT_W(CNT_W)) u_win_dec (
      .code_i(win_code_q), .len_o(win_len)
   );

   wwdt_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .en(en_q), .win(win_q), .restart(upd_q),
      .tmo_len(tmo_len), .win_len(win_len), .tick(tick), .kick(kick),
      .rst_req(rst_req)
   );

   assert_pulse_after_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req && !kick) |=> !rst_req)
      else $error("reset request longer than one cycle");

endmodule

// File: tb/wwdt_top_tb.sv
module wwdt_top_tb;
   localparam int unsigned CODE_W     = 4;
   localparam int unsigned NUM_CODES  = 11;
   localparam int unsigned BASE_SHIFT = 1;
   localparam int unsigned UNLOCK_WIN = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 0, kick = 0, unlock = 0, cfg_we = 0, cfg_en = 0, cfg_window = 0;
   logic [CODE_W-1:0] cfg_tmo_code = '0, cfg_win_code = '0;
   logic lock_req = 0;
   logic rst_req;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   wwdt_top #(.CODE_W(CODE_W), .NUM_CODES(NUM_CODES), .BASE_SHIFT(BASE_SHIFT),
              .UNLOCK_WIN(UNLOCK_WIN)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .kick(kick), .unlock(unlock),
      .cfg_we(cfg_we), .cfg_en(cfg_en), .cfg_window(cfg_window),
      .cfg_tmo_code(cfg_tmo_code), .cfg_win_code(cfg_win_code),
      .lock_req(lock_req), .rst_req(rst_req)
   );

   function automatic int plen(input int c);
      int k;
      k = (c < NUM_CODES) ? c : NUM_CODES - 1;
      return 1 << (k + BASE_SHIFT);
   endfunction

   task automatic chk(input string req, input logic act, input logic exp, input string what);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic step_tick(output logic r);
      @(negedge clk) tick = 1;
      @(negedge clk) tick = 0;
      r = rst_req;
   endtask

   // n ticks that must all stay quiet; one check
   task automatic quiet_ticks(input int n, input string req);
      logic r;
      logic any;
      any = 0;
      for (int i = 0; i < n; i++) begin
         step_tick(r);
         any = any | r;
      end
      chk(req, any, 1'b0, $sformatf("quiet over %0d ticks", n));
   endtask

   task automatic expect_fire(input string req);
      logic r;
      step_tick(r);
      chk(req, r, 1'b1, "fire on final tick");
      @(negedge clk);
      chk("R7", rst_req, 1'b0, "pulse one cycle wide");
   endtask

   task automatic kick_chk(input logic exp, input string req, input logic with_tick);
      @(negedge clk) begin kick = 1; tick = with_tick; end
      @(negedge clk) begin kick = 0; tick = 0; end
      chk(req, rst_req, exp, "after kick");
      if (exp) begin
         @(negedge clk);
         chk("R7", rst_req, 1'b0, "pulse one cycle wide after kick fault");
      end
   endtask

   task automatic set_fields(input logic en, input logic w, input int t, input int wc);
      cfg_en = en; cfg_window = w;
      cfg_tmo_code = CODE_W'(t); cfg_win_code = CODE_W'(wc);
   endtask

   // gap: idle clocks between unlock and write; gap < 0 means same clock
   task automatic wr(input int gap, input logic en, input logic w, input int t, input int wc);
      @(negedge clk) set_fields(en, w, t, wc);
      if (gap < 0) begin
         unlock = 1; cfg_we = 1;
         @(negedge clk) begin unlock = 0; cfg_we = 0; end
      end else begin
         unlock = 1;
         @(negedge clk) unlock = 0;
         repeat (gap) @(negedge clk);
         cfg_we = 1;
         @(negedge clk) cfg_we = 0;
      end
   endtask

   task automatic wr_raw(input logic en, input logic w, input int t, input int wc);
      @(negedge clk) begin set_fields(en, w, t, wc); cfg_we = 1; end
      @(negedge clk) cfg_we = 0;
   endtask

   task automatic do_reset();
      @(negedge clk) rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      do_reset();
      @(negedge clk);
      chk("R1", rst_req, 1'b0, "reset value");
      quiet_ticks(40, "R1");
      kick_chk(1'b0, "R1", 1'b0);

      // R2 R3: every code in normal mode, reserved codes clamp
      for (int c = 0; c < (1 << CODE_W); c++) begin
         wr(0, 1, 0, c, 0);
         quiet_ticks(plen(c) - 1, "R3");
         expect_fire($sformatf("R2 code %0d", c));
         if (c == 3) begin
            quiet_ticks(plen(c) - 1, "R7");
            expect_fire("R7");
         end
      end

      // R4: kick restarts; kick beats a same-clock tick
      wr(0, 1, 0, 2, 0);
      quiet_ticks(5, "R4");
      kick_chk(1'b0, "R4", 1'b0);
      quiet_ticks(7, "R4");
      expect_fire("R4");
      quiet_ticks(5, "R4");
      kick_chk(1'b0, "R4", 1'b1);
      quiet_ticks(7, "R4");
      expect_fire("R4");

      // R11: idle clocks do not count
      quiet_ticks(3, "R11");
      repeat (30) @(negedge clk);
      chk("R11", rst_req, 1'b0, "idle clocks");
      quiet_ticks(4, "R11");
      expect_fire("R11");

      // R5 R6: window mode sweep
      for (int ti = 0; ti < 3; ti++) begin
         for (int wi = 0; wi < 4; wi++) begin
            int t, w, tl, wl;
            t = (ti == 2) ? 4 : ti;
            w = (wi == 3) ? 13 : wi * 2;
            tl = plen(t); wl = plen(w);
            wr(1, 1, 1, t, w);
            quiet_ticks(wl - 1, "R5");
            kick_chk(1'b1, "R5", 1'b0);
            quiet_ticks(wl, "R6");
            kick_chk(1'b0, "R6", 1'b0);
            quiet_ticks(wl + tl - 1, "R6");
            kick_chk(1'b0, "R6", 1'b0);
            quiet_ticks(wl + tl - 1, "R6");
            expect_fire("R6");
            kick_chk(1'b1, "R7", 1'b0);
         end
      end

      // R8: disabled ignores ticks and kicks
      wr(2, 0, 1, 0, 0);
      quiet_ticks(300, "R8");
      kick_chk(1'b0, "R8", 1'b0);
      wr(2, 0, 0, 0, 0);
      kick_chk(1'b0, "R8", 1'b1);
      quiet_ticks(20, "R8");

      // R9: write acceptance window edges
      wr_raw(1, 0, 0, 0);
      quiet_ticks(10, "R9");
      wr(-1, 1, 0, 0, 0);
      quiet_ticks(10, "R9");
      wr(UNLOCK_WIN, 1, 0, 0, 0);
      quiet_ticks(10, "R9");
      wr(UNLOCK_WIN - 1, 1, 0, 0, 0);
      quiet_ticks(1, "R9");
      expect_fire("R9");
      quiet_ticks(1, "R9");
      wr(0, 1, 0, 2, 0);
      quiet_ticks(7, "R9");
      expect_fire("R9");

      // R10: lock freezes settings until reset
      wr(0, 1, 0, 0, 0);
      @(negedge clk) lock_req = 1;
      @(negedge clk) lock_req = 0;
      wr(0, 0, 0, 0, 0);
      quiet_ticks(1, "R10");
      expect_fire("R10");
      wr(1, 1, 0, 5, 0);
      quiet_ticks(1, "R10");
      expect_fire("R10");
      do_reset();
      @(negedge clk);
      chk("R1", rst_req, 1'b0, "reset value after lock");
      quiet_ticks(20, "R10");
      wr(0, 1, 0, 1, 0);
      quiet_ticks(3, "R10");
      expect_fire("R10");

      done = 1;
      summary();
      $finish;
   end

endmodule